// File: doc/BRIEF.md
# Floppy data rate and precompensation control

This block keeps the two write-only rate-related registers of a floppy disk controller. One is the data rate select register; the other is the configuration control register. The active transfer rate follows whichever of the two registers the host wrote last. The data rate select register also carries three more fields: a write precompensation code, a manual low-power request and a self-clearing software reset. The block turns these into signals for the rest of the controller.

Downstream logic receives the following:
- a 2-bit rate code;
- a decoded precompensation step count with a "use the rate's default delay" flag;
- a low-power level that stops the clock and data separator;
- a one-cycle soft-reset pulse.

The rate and the density signal are also mapped onto two drive-density pins according to a 2-bit drive type setting. The delay line and the data separator themselves sit outside this block.

Top module: `fdc_rate_ctl`

## Requirements
- R1: Synchronous reset loads the rate select register value 02h: rate code 10 (250 Kbps) and precompensation code 000. After reset, low_power is 0 and soft_rst is 0.
- R2: A pulse on wr_dsr or on wr_ccr loads wdata[1:0] into rate_code, visible after the next clock edge. If both strobes pulse in the same cycle, the configuration control write wins. Without a strobe, rate_code holds its value.
- R3: A wr_dsr pulse with wdata[7]=1 produces exactly one cycle of soft_rst after the next edge. The other fields of that write are still loaded. soft_rst is 0 in every other cycle.
- R4: A wr_dsr pulse with wdata[6]=1 and wdata[7]=0 sets low_power after the next edge. low_power stays set through later rate select writes with wdata[6]=0 and through configuration control writes.
- R5: low_power clears after the edge that follows a pulse on fifo_acc or msr_acc, or after a rate select write with wdata[7]=1. A same-cycle write with wdata[6]=1 and wdata[7]=0 takes priority over an access. A write with both bit 7 and bit 6 set leaves low_power at 0.
- R6: The precompensation code is wdata[4:2] of a rate select write. The outputs decode from the code as follows:
  - code 000 gives pcomp_dflt=1 and pcomp_steps=0;
  - codes 001 to 110 give pcomp_dflt=0 and pcomp_steps equal to the code;
  - code 111 gives pcomp_dflt=0 and pcomp_steps=0, meaning zero delay.
- R7: A configuration control write leaves the precompensation code unchanged.
- R8: The density signal is 1 for rate codes 00 (500 Kbps) and 11 (1 Mbps) and 0 otherwise. dens_pin[1:0] depends on drv_type and follows drv_type combinationally:
  - drv_type 00 gives {density, rate[0]};
  - drv_type 01 gives {~density, rate[0]};
  - drv_type 10 gives {rate[1], rate[0]};
  - drv_type 11 gives {rate[0], rate[1]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_dsr | input | 1 | One-cycle write strobe for the data rate select register |
| wr_ccr | input | 1 | One-cycle write strobe for the configuration control register |
| wdata | input | 8 | Write data for either register |
| fifo_acc | input | 1 | One-cycle pulse for any access to the data register |
| msr_acc | input | 1 | One-cycle pulse for any access to the main status register |
| drv_type | input | 2 | Drive type selecting the density pin mapping |
| rate_code | output | 2 | Active data rate code |
| pcomp_steps | output | 3 | Precompensation delay in rate-dependent steps |
| pcomp_dflt | output | 1 | Use the default precompensation delay for the rate |
| low_power | output | 1 | Manual low-power state |
| soft_rst | output | 1 | One-cycle software reset pulse |
| dens_pin | output | 2 | Drive density pins |

## Verification
Alternating writes to the two registers, including same-cycle writes to both, check that the rate follows the most recent writer and not one fixed register. Configuration control writes carrying non-zero upper bits check that they leave the precompensation code alone. Low-power entry is tested against each wake source, against the priority between a same-cycle entry write and an access, and against writes combining reset and low-power bits. Sweeping all rates under all four drive types separates the density-inverting, swapped and pass-through mappings. Random strobe and data mixes then catch interaction errors that the directed cases miss.

// File: rtl/fdc_rate_pkg.sv
package fdc_rate_pkg;
  localparam int DATA_W = 8;
  localparam int RATE_W = 2;
  localparam int PC_W   = 3;
  localparam logic [DATA_W-1:0] DSR_RST_VAL = 8'h02;

  typedef enum logic [1:0] {
    DT_DENS     = 2'b00,
    DT_DENS_INV = 2'b01,
    DT_RATE     = 2'b10,
    DT_RATE_SWP = 2'b11
  } drv_type_e;

  function automatic logic density_of(input logic [RATE_W-1:0] rate);
    return (rate == 2'b00) || (rate == 2'b11);
  endfunction
endpackage

// File: rtl/fdc_rate_regs.sv
module fdc_rate_regs #(
  parameter int DATA_W = 8,
  parameter int RATE_W = 2,
  parameter int PC_W   = 3,
  parameter logic [DATA_W-1:0] RST_VAL = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_dsr,
  input  logic              wr_ccr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fifo_acc,
  input  logic              msr_acc,
  output logic [RATE_W-1:0] rate_q,
  output logic [PC_W-1:0]   pc_q,
  output logic              lp_q,
  output logic              srst_q
);
  localparam int PC_LSB   = RATE_W;
  localparam int PC_MSB   = PC_LSB + PC_W - 1;
  localparam int SRST_BIT = DATA_W - 1;
  localparam int LP_BIT   = DATA_W - 2;

  logic srst_req, lp_req, wake;
  logic unused_rsvd;

  assign srst_req    = wr_dsr & wdata[SRST_BIT];
  assign lp_req      = wr_dsr & wdata[LP_BIT];
  assign wake        = fifo_acc | msr_acc;
  assign unused_rsvd = ^wdata[LP_BIT-1:PC_MSB+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= RST_VAL[RATE_W-1:0];
      pc_q   <= RST_VAL[PC_MSB:PC_LSB];
      lp_q   <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      srst_q <= srst_req;
      if (wr_ccr)
        rate_q <= wdata[RATE_W-1:0];
      else if (wr_dsr)
        rate_q <= wdata[RATE_W-1:0];
      if (wr_dsr)
        pc_q <= wdata[PC_MSB:PC_LSB];
      if (srst_req)
        lp_q <= 1'b0;
      else if (lp_req)
        lp_q <= 1'b1;
      else if (wake)
        lp_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fdc_pcomp_dec.sv
module fdc_pcomp_dec #(
  parameter int PC_W = 3
) (
  input  logic [PC_W-1:0] pc_code,
  output logic [PC_W-1:0] steps,
  output logic            use_dflt
);
  localparam logic [PC_W-1:0] CODE_DFLT = '0;
  localparam logic [PC_W-1:0] CODE_ZERO = '1;

  always_comb begin
    use_dflt = (pc_code == CODE_DFLT);
    if (pc_code == CODE_ZERO)
      steps = '0;
    else
      steps = pc_code;
  end
endmodule

// File: rtl/fdc_dens_map.sv
module fdc_dens_map
  import fdc_rate_pkg::*;
(
  input  logic [1:0] rate,
  input  logic [1:0] dtype,
  output logic [1:0] pins
);
  logic dens;
  assign dens = density_of(rate);

  always_comb begin
    case (drv_type_e'(dtype))
      DT_DENS:     pins = {dens, rate[0]};
      DT_DENS_INV: pins = {~dens, rate[0]};
      DT_RATE:     pins = {rate[1], rate[0]};
      default:     pins = {rate[0], rate[1]};
    endcase
  end
endmodule

// File: rtl/fdc_rate_ctl.sv
module fdc_rate_ctl
  import fdc_rate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_dsr,
  input  logic              wr_ccr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fifo_acc,
  input  logic              msr_acc,
  input  logic [1:0]        drv_type,
  output logic [RATE_W-1:0] rate_code,
  output logic [PC_W-1:0]   pcomp_steps,
  output logic              pcomp_dflt,
  output logic              low_power,
  output logic              soft_rst,
  output logic [1:0]        dens_pin
);
  logic [PC_W-1:0] pc_q;

  fdc_rate_regs #(
    .DATA_W (DATA_W),
    .RATE_W (RATE_W),
    .PC_W   (PC_W),
    .RST_VAL(DSR_RST_VAL)
  ) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_dsr  (wr_dsr),
    .wr_ccr  (wr_ccr),
    .wdata   (wdata),
    .fifo_acc(fifo_acc),
    .msr_acc (msr_acc),
    .rate_q  (rate_code),
    .pc_q    (pc_q),
    .lp_q    (low_power),
    .srst_q  (soft_rst)
  );

  fdc_pcomp_dec #(.PC_W(PC_W)) pcomp_i (
    .pc_code (pc_q),
    .steps   (pcomp_steps),
    .use_dflt(pcomp_dflt)
  );

  fdc_dens_map dens_i (
    .rate (rate_code),
    .dtype(drv_type),
    .pins (dens_pin)
  );
endmodule

// File: rtl/fdc_rate_ctl_chk.sv
module fdc_rate_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_dsr,
  input logic       wr_ccr,
  input logic [7:0] wdata,
  input logic       fifo_acc,
  input logic       msr_acc,
  input logic [1:0] rate_code,
  input logic [2:0] pcomp_steps,
  input logic       pcomp_dflt,
  input logic       low_power,
  input logic       soft_rst
);
  logic unused_chk;
  assign unused_chk = ^wdata[5:2];

  p_rate_ccr_r2: assert property (@(posedge clk) disable iff (rst)
    wr_ccr |=> rate_code == $past(wdata[1:0]));
  p_rate_dsr_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_dsr && !wr_ccr) |=> rate_code == $past(wdata[1:0]));
  p_rate_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!wr_dsr && !wr_ccr) |=> $stable(rate_code));
  p_srst_on_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_dsr && wdata[7]) |=> soft_rst);
  p_srst_off_r3: assert property (@(posedge clk) disable iff (rst)
    !(wr_dsr && wdata[7]) |=> !soft_rst);
  p_lp_enter_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_dsr && wdata[6] && !wdata[7]) |=> low_power);
  p_lp_wake_r5: assert property (@(posedge clk) disable iff (rst)
    ((fifo_acc || msr_acc) && !(wr_dsr && wdata[6])) |=> !low_power);
  p_lp_srst_r5: assert property (@(posedge clk) disable iff (rst)
    soft_rst |-> !low_power);
  p_pcomp_dflt_r6: assert property (@(posedge clk) disable iff (rst)
    pcomp_dflt |-> pcomp_steps == 3'd0);
  p_pcomp_ccr_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_ccr && !wr_dsr) |=> $stable(pcomp_steps) && $stable(pcomp_dflt));
endmodule

bind fdc_rate_ctl fdc_rate_ctl_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .wr_dsr     (wr_dsr),
  .wr_ccr     (wr_ccr),
  .wdata      (wdata),
  .fifo_acc   (fifo_acc),
  .msr_acc    (msr_acc),
  .rate_code  (rate_code),
  .pcomp_steps(pcomp_steps),
  .pcomp_dflt (pcomp_dflt),
  .low_power  (low_power),
  .soft_rst   (soft_rst)
);

// File: tb/fdc_rate_ctl_tb_top.sv
`timescale 1ns/1ps
module fdc_rate_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_dsr = 1'b0, wr_ccr = 1'b0, fifo_acc = 1'b0, msr_acc = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [1:0] drv_type = 2'b00;
  logic [1:0] rate_code, dens_pin;
  logic [2:0] pcomp_steps;
  logic       pcomp_dflt, low_power, soft_rst;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [1:0] e_rate;
  logic [2:0] e_pc;
  logic       e_lp, e_srst;

  always #2.5 clk = ~clk;

  fdc_rate_ctl dut_i (
    .clk(clk), .rst(rst), .wr_dsr(wr_dsr), .wr_ccr(wr_ccr), .wdata(wdata),
    .fifo_acc(fifo_acc), .msr_acc(msr_acc), .drv_type(drv_type),
    .rate_code(rate_code), .pcomp_steps(pcomp_steps), .pcomp_dflt(pcomp_dflt),
    .low_power(low_power), .soft_rst(soft_rst), .dens_pin(dens_pin)
  );

  function automatic logic [1:0] exp_pins(input logic [1:0] r, input logic [1:0] t);
    logic d;
    d = (r == 2'b00) || (r == 2'b11);
    case (t)
      2'b00:   return {d, r[0]};
      2'b01:   return {~d, r[0]};
      2'b10:   return {r[1], r[0]};
      default: return {r[0], r[1]};
    endcase
  endfunction

  function automatic logic [2:0] exp_steps(input logic [2:0] c);
    return (c == 3'b111) ? 3'd0 : c;
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp({tag, "/R2"}, "rate_code", rate_code, e_rate);
    cmp({tag, "/R6"}, "pcomp_steps", pcomp_steps, exp_steps(e_pc));
    cmp({tag, "/R6"}, "pcomp_dflt", pcomp_dflt, e_pc == 3'b000);
    cmp({tag, "/R5"}, "low_power", low_power, e_lp);
    cmp({tag, "/R3"}, "soft_rst", soft_rst, e_srst);
    cmp({tag, "/R8"}, "dens_pin", dens_pin, exp_pins(e_rate, drv_type));
  endtask

  // check the state from the last edge, then drive one cycle and advance the model
  task automatic step(input string tag, input logic ds, input logic cc,
                      input logic [7:0] d, input logic fa, input logic ma,
                      input logic [1:0] dt);
    @(negedge clk);
    check_all(tag);
    wr_dsr = ds; wr_ccr = cc; wdata = d; fifo_acc = fa; msr_acc = ma; drv_type = dt;
    e_srst = ds && d[7];
    if (cc) e_rate = d[1:0];
    else if (ds) e_rate = d[1:0];
    if (ds) e_pc = d[4:2];
    if (ds && d[7]) e_lp = 1'b0;
    else if (ds && d[6]) e_lp = 1'b1;
    else if (fa || ma) e_lp = 1'b0;
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, drv_type);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0d5c));
    e_rate = 2'b10; e_pc = 3'b000; e_lp = 1'b0; e_srst = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check_all("R1");
    cmp("R1", "dens_pin", dens_pin, 2'b00);

    // R2: last writer wins, both directions, same-cycle collision
    step("R2", 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 2'b00);
    step("R2", 1'b0, 1'b1, 8'h03, 1'b0, 1'b0, 2'b00);
    step("R2", 1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 2'b00);
    step("R2", 1'b1, 1'b1, 8'h02, 1'b0, 1'b0, 2'b00);
    idle("R2");
    // R7: config write with upper bits leaves precomp code alone
    step("R7", 1'b1, 1'b0, 8'h14, 1'b0, 1'b0, 2'b00);
    step("R7", 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, 2'b00);
    idle("R7");
    // R6: every precompensation code
    for (int c = 0; c < 8; c++) begin
      step("R6", 1'b1, 1'b0, {3'b000, c[2:0], 2'b10}, 1'b0, 1'b0, 2'b00);
      idle("R6");
    end
    // R3: soft reset pulse still loads fields
    step("R3", 1'b1, 1'b0, 8'h8F, 1'b0, 1'b0, 2'b00);
    idle("R3");
    idle("R3");
    // R4: enter low power, survive other writes
    step("R4", 1'b1, 1'b0, 8'h40, 1'b0, 1'b0, 2'b00);
    step("R4", 1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 2'b00);
    step("R4", 1'b0, 1'b1, 8'h02, 1'b0, 1'b0, 2'b00);
    idle("R4");
    cmp("R4", "low_power held", low_power, 1);
    // R5: wake sources and priorities
    step("R5", 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 2'b00);
    step("R5", 1'b1, 1'b0, 8'h40, 1'b0, 1'b0, 2'b00);
    step("R5", 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 2'b00);
    step("R5", 1'b1, 1'b0, 8'h40, 1'b0, 1'b0, 2'b00);
    step("R5", 1'b1, 1'b0, 8'h80, 1'b0, 1'b0, 2'b00);
    step("R5", 1'b1, 1'b0, 8'h40, 1'b1, 1'b1, 2'b00);
    step("R5", 1'b1, 1'b0, 8'hC0, 1'b0, 1'b0, 2'b00);
    idle("R5");
    cmp("R5", "low_power after bit7+bit6", low_power, 0);
    // R8: all rates under all drive types
    for (int t = 0; t < 4; t++)
      for (int r = 0; r < 4; r++) begin
        step("R8", 1'b0, 1'b1, {6'd0, r[1:0]}, 1'b0, 1'b0, t[1:0]);
        idle("R8");
      end
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      step("RND", ($urandom % 5) == 0, ($urandom % 6) == 0, d,
           ($urandom % 7) == 0, ($urandom % 7) == 0, 2'($urandom));
    end
    idle("RND");
    @(negedge clk);
    check_all("END");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule